// File: doc/BRIEF.md
# Tile Stream Reorder Buffer

This block turns a stream of image words that arrives tile by tile into writes to a flat, row-major output memory. A band of the image is `TILE_H` rows tall and holds `TILES_ACROSS` tiles side by side, each `TILE_H` x `TILE_W` words. Within a tile the stream carries rows in turn, and within a row it carries columns in turn. Tiles arrive left to right.

Each tile is captured into one of two local banks. Once a bank is full it is drained to the write port with the address that the word has in the full image. The drain of one tile runs while the next tile fills the other bank. The input is a valid/ready stream plus a band index. The output is a write port with valid, ready, address and data, and a one-cycle pulse marks the end of each band.

Top module: `tile_reorder`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `in_ready` is 1, `wr_valid` is 0 and `band_done` is 0.
- R2: The word at row m, column n of tile j in band b is written to address b*TILE_H*TILES_ACROSS*TILE_W + m*TILES_ACROSS*TILE_W + j*TILE_W + n. Every address of the band is written exactly once.
- R3: Words leave the write port in the order they were accepted: row by row and column by column within a tile, with tiles in increasing j.
- R4: One word moves per cycle on each side. If input is continuous and `wr_ready` stays high, `in_ready` never drops. The first word of a tile is offered in the cycle after its last word is accepted, and the last write of a tile comes TILE_H*TILE_W cycles after that tile's last accepted word.
- R5: A bank is refilled only after it has been fully drained. With `wr_ready` held low, exactly 2*TILE_H*TILE_W words are accepted before `in_ready` goes to 0, and while `in_ready` is 0 `wr_valid` is 1.
- R6: While `wr_valid` is 1 and `wr_ready` is 0, `wr_addr` and `wr_data` hold their values and `wr_valid` stays 1. No word is lost or repeated.
- R7: `band_done` is a one-cycle pulse. It is raised in the cycle after the write of the last word of tile TILES_ACROSS-1, once per band.
- R8: `band_idx` is sampled when the first word of a band (tile 0, row 0, column 0) is accepted. Changes to it later in the band do not affect that band's addresses.
- R9: A reset in the middle of a band discards the partial tile and returns the fill and drain positions to the start, so the next accepted word is treated as tile 0, row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | DATA_W | Input word |
| band_idx | input | BAND_W | Band number, sampled at the first word of a band |
| wr_valid | output | 1 | Write request present |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Row-major write address |
| wr_data | output | DATA_W | Write data |
| band_done | output | 1 | Pulse after the last write of a band |

## Verification
A wrong fill position or a wrong bank tag shows up as a wrong address on the very write that carries the bad word. This happens at most one tile after the fault, because every word of every band is compared against the address formula and against the order of acceptance. A full flag that is stuck, or cleared too early, shows at the ports within two tiles. In that case `in_ready` either stays low with no write pending, or an overwritten bank produces repeated or missing addresses. A drain counter that slips on a stall produces a duplicate or missing address in the same tile, and a wrong tile tag moves `band_done` away from the cycle after the final write.

// File: rtl/tile_reorder_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the tile reorder buffer.
// Assumes: callers pass positive counts.
package tile_reorder_pkg;
    // Counter width for a range of n values, never below one bit.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/tile_fill_ctrl.sv
`timescale 1ns/1ps
// Fill controller: steps through the words of each incoming tile, picks the
// bank being filled and latches the band number at the first word of a band.
// Assumes: buf_full reports which banks still hold an undrained tile.
module tile_fill_ctrl
    import tile_reorder_pkg::*;
#(
    parameter int DEPTH        = 12,
    parameter int TILES_ACROSS = 3,
    parameter int BAND_W       = 4,
    parameter int IDX_W        = cnt_w(DEPTH),
    parameter int TJ_W         = cnt_w(TILES_ACROSS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BAND_W-1:0] band_idx,
    input  logic [1:0]        buf_full,
    output logic              in_ready,
    output logic              wr_en,
    output logic              wr_sel,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              seal,
    output logic [TJ_W-1:0]   seal_tile,
    output logic [BAND_W-1:0] seal_band
);
    logic [IDX_W-1:0]  idx_q;
    logic [TJ_W-1:0]   tile_q;
    logic              sel_q;
    logic [BAND_W-1:0] band_q;
    logic              accept;
    logic              last_word;
    logic              band_start;

    assign in_ready   = !buf_full[sel_q];
    assign accept     = in_valid && in_ready;
    assign last_word  = (idx_q == IDX_W'(DEPTH - 1));
    assign band_start = (tile_q == '0) && (idx_q == '0);

    assign wr_en     = accept;
    assign wr_sel    = sel_q;
    assign wr_idx    = idx_q;
    assign seal      = accept && last_word;
    assign seal_tile = tile_q;
    assign seal_band = band_start ? band_idx : band_q;

    // Advance the word, tile and bank positions on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            tile_q <= '0;
            sel_q  <= 1'b0;
            band_q <= '0;
        end else if (accept) begin
            if (band_start) begin
                band_q <= band_idx;
            end
            if (last_word) begin
                idx_q  <= '0;
                sel_q  <= !sel_q;
                tile_q <= (tile_q == TJ_W'(TILES_ACROSS - 1)) ? '0 : tile_q + 1'b1;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tile_pingpong_buf.sv
`timescale 1ns/1ps
// Two tile banks with per-bank full flags and tile/band tags.
// Assumes: a bank is never written while full and never drained while empty.
module tile_pingpong_buf
    import tile_reorder_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int DEPTH        = 12,
    parameter int TILES_ACROSS = 3,
    parameter int BAND_W       = 4,
    parameter int IDX_W        = cnt_w(DEPTH),
    parameter int TJ_W         = cnt_w(TILES_ACROSS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              seal,
    input  logic [TJ_W-1:0]   seal_tile,
    input  logic [BAND_W-1:0] seal_band,
    input  logic              rd_sel,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              drained,
    output logic [1:0]        buf_full,
    output logic [DATA_W-1:0] rd_word,
    output logic [TJ_W-1:0]   rd_tile,
    output logic [BAND_W-1:0] rd_band
);
    localparam int NBANK = 2;

    logic [1:0]        full_q;
    logic [DATA_W-1:0] word_b [NBANK];
    logic [TJ_W-1:0]   tile_b [NBANK];
    logic [BAND_W-1:0] band_b [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DATA_W-1:0] mem_q [DEPTH];
        logic [TJ_W-1:0]   tile_q;
        logic [BAND_W-1:0] band_q;

        // Store an accepted word into this bank.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == 1'(b))) begin
                mem_q[wr_idx] <= wr_word;
            end
        end

        // Record the tile and band of the tile sealed into this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tile_q <= '0;
                band_q <= '0;
            end else if (seal && (wr_sel == 1'(b))) begin
                tile_q <= seal_tile;
                band_q <= seal_band;
            end
        end

        assign word_b[b] = mem_q[rd_idx];
        assign tile_b[b] = tile_q;
        assign band_b[b] = band_q;
    end

    // Mark a bank full when sealed and empty when its drain completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= '0;
        end else begin
            if (seal) begin
                full_q[wr_sel] <= 1'b1;
            end
            if (drained) begin
                full_q[rd_sel] <= 1'b0;
            end
        end
    end

    assign buf_full = full_q;
    assign rd_word  = word_b[rd_sel];
    assign rd_tile  = tile_b[rd_sel];
    assign rd_band  = band_b[rd_sel];
endmodule

// File: rtl/tile_drain_ctrl.sv
`timescale 1ns/1ps
// Drain controller: walks the full bank in row-then-column order, forms the
// row-major image address and flags the end of each band.
// Assumes: slot_full, tile and band describe the bank selected by rd_sel.
module tile_drain_ctrl
    import tile_reorder_pkg::*;
#(
    parameter int TILE_H       = 3,
    parameter int TILE_W       = 4,
    parameter int TILES_ACROSS = 3,
    parameter int BAND_W       = 4,
    parameter int ADDR_W       = 10,
    parameter int IDX_W        = cnt_w(TILE_H * TILE_W),
    parameter int TJ_W         = cnt_w(TILES_ACROSS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_full,
    input  logic [TJ_W-1:0]   tile,
    input  logic [BAND_W-1:0] band,
    input  logic              wr_ready,
    output logic              rd_sel,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              drained,
    output logic              band_done
);
    localparam int ROW_W      = cnt_w(TILE_H);
    localparam int COL_W      = cnt_w(TILE_W);
    localparam int DEPTH      = TILE_H * TILE_W;
    localparam int ROW_WORDS  = TILES_ACROSS * TILE_W;
    localparam int BAND_WORDS = TILE_H * ROW_WORDS;

    logic             sel_q;
    logic [IDX_W-1:0] idx_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             done_q;
    logic             fire;
    logic             last_word;

    assign wr_valid  = slot_full;
    assign fire      = wr_valid && wr_ready;
    assign last_word = (idx_q == IDX_W'(DEPTH - 1));
    assign drained   = fire && last_word;
    assign rd_sel    = sel_q;
    assign rd_idx    = idx_q;
    assign band_done = done_q;

    assign wr_addr = ADDR_W'(band) * ADDR_W'(BAND_WORDS)
                   + ADDR_W'(row_q) * ADDR_W'(ROW_WORDS)
                   + ADDR_W'(tile) * ADDR_W'(TILE_W)
                   + ADDR_W'(col_q);

    // Step row, column and bank on each accepted write; pulse at band end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            idx_q  <= '0;
            row_q  <= '0;
            col_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= drained && (tile == TJ_W'(TILES_ACROSS - 1));
            if (fire) begin
                if (col_q == COL_W'(TILE_W - 1)) begin
                    col_q <= '0;
                    row_q <= (row_q == ROW_W'(TILE_H - 1)) ? '0 : row_q + 1'b1;
                end else begin
                    col_q <= col_q + 1'b1;
                end
                if (last_word) begin
                    idx_q <= '0;
                    sel_q <= !sel_q;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tile_reorder.sv
`timescale 1ns/1ps
// Tile stream reorder buffer top: captures tiles into two alternating banks
// and writes them out at their row-major image addresses.
// Assumes: the write memory spans 2**BAND_W bands of TILE_H image rows.
module tile_reorder
    import tile_reorder_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int TILE_H       = 3,
    parameter int TILE_W       = 4,
    parameter int TILES_ACROSS = 3,
    parameter int BAND_W       = 4,
    localparam int ADDR_W      = cnt_w(TILE_H * TILE_W * TILES_ACROSS) + BAND_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [BAND_W-1:0] band_idx,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              band_done
);
    localparam int DEPTH = TILE_H * TILE_W;
    localparam int IDX_W = cnt_w(DEPTH);
    localparam int TJ_W  = cnt_w(TILES_ACROSS);

    logic [1:0]        buf_full;
    logic              f_en;
    logic              f_sel;
    logic [IDX_W-1:0]  f_idx;
    logic              f_seal;
    logic [TJ_W-1:0]   f_tile;
    logic [BAND_W-1:0] f_band;
    logic              d_sel;
    logic [IDX_W-1:0]  d_idx;
    logic              d_drained;
    logic [TJ_W-1:0]   d_tile;
    logic [BAND_W-1:0] d_band;
    logic              d_full;

    assign d_full = buf_full[d_sel];

    tile_fill_ctrl #(
        .DEPTH(DEPTH), .TILES_ACROSS(TILES_ACROSS), .BAND_W(BAND_W),
        .IDX_W(IDX_W), .TJ_W(TJ_W)
    ) fill_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .band_idx(band_idx),
        .buf_full(buf_full), .in_ready(in_ready), .wr_en(f_en), .wr_sel(f_sel),
        .wr_idx(f_idx), .seal(f_seal), .seal_tile(f_tile), .seal_band(f_band)
    );

    tile_pingpong_buf #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .TILES_ACROSS(TILES_ACROSS),
        .BAND_W(BAND_W), .IDX_W(IDX_W), .TJ_W(TJ_W)
    ) buf_i (
        .clk(clk), .rst_n(rst_n), .wr_en(f_en), .wr_sel(f_sel), .wr_idx(f_idx),
        .wr_word(in_data), .seal(f_seal), .seal_tile(f_tile), .seal_band(f_band),
        .rd_sel(d_sel), .rd_idx(d_idx), .drained(d_drained), .buf_full(buf_full),
        .rd_word(wr_data), .rd_tile(d_tile), .rd_band(d_band)
    );

    tile_drain_ctrl #(
        .TILE_H(TILE_H), .TILE_W(TILE_W), .TILES_ACROSS(TILES_ACROSS),
        .BAND_W(BAND_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TJ_W(TJ_W)
    ) drain_i (
        .clk(clk), .rst_n(rst_n), .slot_full(d_full), .tile(d_tile), .band(d_band),
        .wr_ready(wr_ready), .rd_sel(d_sel), .rd_idx(d_idx), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .drained(d_drained), .band_done(band_done)
    );
endmodule

// File: rtl/tile_reorder_chk.sv
`timescale 1ns/1ps
// Port-level protocol checks for tile_reorder, attached by bind.
// Assumes: a tile holds more than one word, so band ends are never adjacent.
module tile_reorder_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
)(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              band_done
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_ready && !wr_valid && !band_done));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R5
    full_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> wr_valid);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        band_done |=> !band_done);

    // R7
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        band_done |-> $past(wr_valid && wr_ready));
endmodule

bind tile_reorder tile_reorder_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .band_done(band_done)
);

// File: tb/tile_reorder_tb_top.sv
`timescale 1ns/1ps
// Directed bench for tile_reorder: one task per scenario.
module tile_reorder_tb_top;
    localparam int DW    = 16;
    localparam int TH    = 3;
    localparam int TW    = 4;
    localparam int TT    = 3;
    localparam int BW    = 4;
    localparam int AW    = $clog2(TH * TW * TT) + BW;
    localparam int DEPTH = TH * TW;
    localparam int NB    = DEPTH * TT;
    localparam int MSZ   = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic [BW-1:0] band_idx = '0;
    logic          wr_valid;
    logic          wr_ready = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          band_done;

    tile_reorder #(.DATA_W(DW), .TILE_H(TH), .TILE_W(TW), .TILES_ACROSS(TT), .BAND_W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .band_idx(band_idx), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .band_done(band_done)
    );

    always #4 clk = !clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [DW-1:0] exp_mem [MSZ];
    bit            exp_set [MSZ];
    logic [DW-1:0] got_mem [MSZ];
    int            got_cnt [MSZ];
    logic [DW-1:0] in_seq  [512];
    logic [DW-1:0] out_seq [512];
    int acc_cyc [512];
    int wr_cyc  [512];
    int n_in = 0, n_out = 0, acc_cnt = 0, done_cnt = 0, done_cyc = 0, stall_cnt = 0;
    bit rdy_run = 1'b0;
    bit push_busy = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) cyc++;

    // Observe handshakes between edges; each seen here completes at the next edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid && wr_ready) begin
                got_cnt[wr_addr]++;
                got_mem[wr_addr] = wr_data;
                out_seq[n_out] = wr_data;
                wr_cyc[n_out] = cyc;
                n_out++;
            end
            if (in_valid && in_ready) begin
                acc_cyc[acc_cnt] = cyc;
                acc_cnt++;
            end
            if (in_valid && !in_ready) stall_cnt++;
            if (band_done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] step_lfsr(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic clear_tables();
        for (int a = 0; a < MSZ; a++) begin
            exp_set[a] = 1'b0;
            got_cnt[a] = 0;
        end
        n_in = 0; n_out = 0; acc_cnt = 0; done_cnt = 0; stall_cnt = 0;
    endtask

    task automatic do_reset(input int cycles);
        @(posedge clk); #2;
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (cycles) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    // Push nwords of a band; expected address from the row-major formula (R2).
    task automatic push_band(input int band, input int base, input int nwords,
                             input bit gaps, input bit alter_band);
        push_busy = 1'b1;
        @(posedge clk); #2;
        band_idx = BW'(band);
        for (int k = 0; k < nwords; k++) begin
            int j, m, n, a;
            j = k / DEPTH;
            m = (k % DEPTH) / TW;
            n = k % TW;
            a = band * TH * TT * TW + m * TT * TW + j * TW + n;
            in_seq[n_in] = DW'(base + k);
            n_in++;
            exp_mem[a] = DW'(base + k);
            exp_set[a] = 1'b1;
            in_valid = 1'b1;
            in_data = DW'(base + k);
            forever begin
                bit acc;
                @(negedge clk);
                acc = in_ready;
                @(posedge clk); #2;
                if (acc) break;
            end
            if (alter_band && k == 0) band_idx = BW'(band + 5);
            if (gaps) begin
                lfsr = step_lfsr(lfsr);
                if (lfsr[0]) begin
                    in_valid = 1'b0;
                    @(posedge clk); #2;
                end
            end
        end
        in_valid = 1'b0;
        push_busy = 1'b0;
    endtask

    task automatic rand_ready();
        while (rdy_run) begin
            @(posedge clk); #2;
            lfsr = step_lfsr(lfsr);
            wr_ready = lfsr[1] | lfsr[4];
        end
        wr_ready = 1'b1;
    endtask

    task automatic wait_done(input int target);
        for (int c = 0; c < 2000 && done_cnt < target; c++) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic compare_image(input string req);
        int bad = 0, first = -1;
        for (int a = 0; a < MSZ; a++) begin
            int want;
            want = exp_set[a] ? 1 : 0;
            if (got_cnt[a] != want || (want == 1 && got_mem[a] !== exp_mem[a])) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        chk(bad == 0, req, "image addresses wrong, first bad address", first, -1);
        bad = 0;
        for (int i = 0; i < n_in && i < n_out; i++)
            if (out_seq[i] !== in_seq[i]) bad++;
        chk(bad == 0 && n_out == n_in, "R3", "write order / count", n_out, n_in);
    endtask

    task automatic t_reset();
        do_reset(3);
        @(negedge clk);
        chk(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        chk(wr_valid === 1'b0 && band_done === 1'b0, "R1", "wr_valid/band_done after reset",
            int'(wr_valid) + int'(band_done), 0);
    endtask

    task automatic t_full_speed();
        clear_tables();
        wr_ready = 1'b1;
        push_band(2, 100, NB, 1'b0, 1'b0);
        wait_done(1);
        compare_image("R2");
        chk(stall_cnt == 0, "R4", "input stalls at full rate", stall_cnt, 0);
        chk(wr_cyc[0] == acc_cyc[DEPTH-1] + 1, "R4", "first write cycle",
            wr_cyc[0], acc_cyc[DEPTH-1] + 1);
        chk(wr_cyc[NB-1] == acc_cyc[NB-1] + DEPTH, "R4", "last write cycle",
            wr_cyc[NB-1], acc_cyc[NB-1] + DEPTH);
        chk(done_cnt == 1 && done_cyc == wr_cyc[NB-1] + 1, "R7", "done pulse cycle",
            done_cyc, wr_cyc[NB-1] + 1);
    endtask

    task automatic t_backpressure();
        clear_tables();
        rdy_run = 1'b1;
        fork
            rand_ready();
            begin
                push_band(5, 300, NB, 1'b1, 1'b0);
                wait_done(1);
                rdy_run = 1'b0;
            end
        join
        compare_image("R6");
        chk(done_cnt == 1, "R7", "done count under stalls", done_cnt, 1);
    endtask

    task automatic t_fill_block();
        clear_tables();
        wr_ready = 1'b0;
        fork
            push_band(1, 500, NB, 1'b0, 1'b0);
        join_none
        repeat (3 * DEPTH) @(posedge clk);
        @(negedge clk);
        chk(acc_cnt == 2 * DEPTH, "R5", "words taken with write port stalled", acc_cnt, 2 * DEPTH);
        chk(in_ready === 1'b0 && wr_valid === 1'b1 && n_out == 0, "R5", "blocked state",
            int'(in_ready), 0);
        @(posedge clk); #2;
        wr_ready = 1'b1;
        wait (!push_busy);
        wait_done(1);
        compare_image("R5");
    endtask

    task automatic t_band_sample();
        clear_tables();
        wr_ready = 1'b1;
        push_band(7, 700, NB, 1'b1, 1'b1);
        wait_done(1);
        compare_image("R8");
    endtask

    task automatic t_two_bands();
        clear_tables();
        wr_ready = 1'b1;
        push_band(15, 900, NB, 1'b0, 1'b0);
        push_band(0, 1000, NB, 1'b0, 1'b0);
        wait_done(2);
        compare_image("R2");
        chk(done_cnt == 2, "R7", "done count for two bands", done_cnt, 2);
    endtask

    task automatic t_mid_reset();
        clear_tables();
        wr_ready = 1'b0;
        push_band(3, 1200, DEPTH + 5, 1'b0, 1'b0);
        do_reset(2);
        @(negedge clk);
        chk(in_ready === 1'b1 && wr_valid === 1'b0, "R9", "state after mid-band reset",
            int'(wr_valid), 0);
        clear_tables();
        wr_ready = 1'b1;
        push_band(4, 1400, NB, 1'b0, 1'b0);
        wait_done(1);
        compare_image("R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_full_speed();
        t_backpressure();
        t_fill_block();
        t_band_sample();
        t_two_bands();
        t_mid_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule